// File: doc/BRIEF.md
# Cascaded Serial Converter Read Controller

This block sits in the host's system clock domain and runs one sample cycle of one or two chained serial analog-to-digital converters each time it is asked. A cycle lowers the read/convert control first and then chip select, so that a conversion starts. It then waits for the busy line to go low and come back high. It then holds chip select low with read/convert high and toggles a data clock that it derives from the system clock.

The serial data and sync inputs are sampled at each falling edge of that generated clock. The first sample with sync high marks the start of the frame, and the bits after it are taken MSB first. With two devices in the chain, the one extra bit between the first device's LSB and the second device's MSB is dropped. The collected words appear together on a wide output with a one-cycle valid strobe.

A busy line that never completes, or a frame with no sync pulse, ends the cycle with a one-cycle error strobe and a return to idle.

Top module: `adc_chain_reader`

## Requirements
- R1: After synchronous reset, cs_n_o and rc_o are high, dclk_o is low, and valid_o and err_o are low.
- R2: A start request drives rc_o low for exactly one cycle with cs_n_o high. Both then stay low together for PULSE_CYC cycles. Both then return high, so rc_o stays low for PULSE_CYC+1 cycles in total.
- R3: After busy_n_i has been seen low and then high again, the controller holds cs_n_o low and rc_o high. During this time dclk_o starts low and changes level every HALF_DIV system cycles.
- R4: dclk_o is never high while cs_n_o is high or rc_o is low.
- R5: Inputs are sampled at each high-to-low change of dclk_o. The first sample with sync_i high opens the frame, and the next 16 data samples form word 0 MSB first. Word 0 is placed at words_o[15:0].
- R6: With DEPTH=2, the sample right after word 0 is discarded whatever its value. The next 16 samples form word 1 at words_o[31:16]. A frame uses 17*DEPTH falling edges of dclk_o in total.
- R7: valid_o is high for exactly one cycle per completed frame. words_o changes only together with valid_o.
- R8: If busy_n_i does not finish its low-then-high sequence within BUSY_TO cycles, err_o pulses for one cycle. The controller then returns to idle with cs_n_o high and gives no valid_o.
- R9: If sync_i is low on each of the first SYNC_WAIT falling samples, err_o pulses and the read ends with chip select released.
- R10: A start request that arrives while a sample cycle is in progress is ignored. No second conversion follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one sample cycle (taken in idle only) |
| busy_n_i | input | 1 | Converter busy, low while converting |
| sdata_i | input | 1 | Serial data from the end of the chain |
| sync_i | input | 1 | Frame sync from the first device |
| cs_n_o | output | 1 | Chip select, active low |
| rc_o | output | 1 | Read/convert control, low requests a conversion |
| dclk_o | output | 1 | Generated data clock |
| words_o | output | 16*DEPTH | Collected words, first device in the low 16 bits |
| valid_o | output | 1 | One-cycle strobe when words_o is updated |
| err_o | output | 1 | One-cycle strobe on busy timeout or missing sync |

## Verification
A bit counter that is off by one shows up at once as a shifted or rotated word on words_o. It also shows as a falling-edge count other than 17 or 34 at the end of the frame. A null-bit slot in the wrong position breaks the boundary between the two words in the first frame whose extra bit differs from its neighbours. A faulty sequencer shows within one sample cycle as a wrong rc_o or cs_n_o pulse width, as clock edges while the device is deselected, or as a missing or doubled valid or error strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PULSE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_READ,
    ST_DONE
  } rd_state_e;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Divided data clock; flags the cycle in which the clock falls.
module adc_rd_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic dclk_o,
  output logic fall_tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          dclk_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      dclk_q <= ~dclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign dclk_o      = dclk_q;
  assign fall_tick_o = run && wrap && dclk_q;
endmodule

// File: rtl/adc_rd_timer.sv
// Cycle counter that flags the LIMIT-th enabled cycle.
module adc_rd_timer #(
  parameter int LIMIT = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (en && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = en && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/adc_rd_deser.sv
// Frame assembler: waits for sync, drops the null slot between words.
module adc_rd_deser #(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 2,
  parameter int SYNC_WAIT = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      tick,
  input  logic                      sdata_i,
  input  logic                      sync_i,
  output logic [DATA_W*DEPTH-1:0]   words_o,
  output logic                      done_o,
  output logic                      nosync_o
);
  localparam int TOTAL = DATA_W * DEPTH;
  localparam int FRAME = TOTAL + DEPTH - 1;
  localparam int KW    = $clog2(FRAME + 1);
  localparam int SLW   = $clog2(DATA_W + 1);
  localparam int SW    = $clog2(SYNC_WAIT + 1);

  logic             synced_q;
  logic [KW-1:0]    k_q;
  logic [SLW-1:0]   slot_q;
  logic [SW-1:0]    wait_q;
  logic [TOTAL-1:0] sh_q;
  logic             null_slot;

  assign null_slot = (slot_q == SLW'(DATA_W));

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else if (tick && synced_q && !null_slot) sh_q <= {sh_q[TOTAL-2:0], sdata_i};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      synced_q <= 1'b0;
      k_q      <= '0;
      slot_q   <= '0;
      wait_q   <= '0;
    end else if (tick) begin
      if (!synced_q) begin
        if (sync_i) synced_q <= 1'b1;
        else        wait_q   <= wait_q + 1'b1;
      end else begin
        k_q    <= k_q + 1'b1;
        slot_q <= null_slot ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign done_o   = tick && synced_q && (k_q == KW'(FRAME - 1));
  assign nosync_o = tick && !synced_q && !sync_i && (wait_q == SW'(SYNC_WAIT - 1));

  // First device shifted in first, so it sits in the upper part of sh_q.
  for (genvar d = 0; d < DEPTH; d++) begin : g_map
    assign words_o[d*DATA_W +: DATA_W] = sh_q[(DEPTH-1-d)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 2,
  parameter int HALF_DIV  = 2,
  parameter int PULSE_CYC = 4,
  parameter int BUSY_TO   = 400,
  parameter int SYNC_WAIT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    busy_n_i,
  input  logic                    sdata_i,
  input  logic                    sync_i,
  output logic                    cs_n_o,
  output logic                    rc_o,
  output logic                    dclk_o,
  output logic [DATA_W*DEPTH-1:0] words_o,
  output logic                    valid_o,
  output logic                    err_o
);
  localparam int WORDS_W = DATA_W * DEPTH;
  localparam int PW      = $clog2(PULSE_CYC + 1);

  rd_state_e          st_q, st_d;
  logic [PW-1:0]      pcnt_q;
  logic               in_wait, run, fall_tick, tmo, done, nosync, err_set;
  logic [WORDS_W-1:0] deser_words;
  logic               cs_n_q, rc_q, valid_q, err_q;
  logic [WORDS_W-1:0] words_q;

  assign in_wait = (st_q == ST_WAIT_LO) || (st_q == ST_WAIT_HI);
  assign run     = (st_q == ST_READ);

  adc_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst(rst), .run(run), .dclk_o(dclk_o), .fall_tick_o(fall_tick)
  );

  adc_rd_timer #(.LIMIT(BUSY_TO)) u_timer (
    .clk(clk), .rst(rst), .clear(!in_wait), .en(in_wait), .expired_o(tmo)
  );

  adc_rd_deser #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_WAIT(SYNC_WAIT)) u_deser (
    .clk(clk), .rst(rst), .clear(!run), .tick(fall_tick),
    .sdata_i(sdata_i), .sync_i(sync_i),
    .words_o(deser_words), .done_o(done), .nosync_o(nosync)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_ARM;
      ST_ARM:     st_d = ST_PULSE;
      ST_PULSE:   if (pcnt_q == PW'(PULSE_CYC - 1)) st_d = ST_WAIT_LO;
      ST_WAIT_LO: if (tmo) st_d = ST_IDLE; else if (!busy_n_i) st_d = ST_WAIT_HI;
      ST_WAIT_HI: if (tmo) st_d = ST_IDLE; else if (busy_n_i) st_d = ST_READ;
      ST_READ:    if (done) st_d = ST_DONE; else if (nosync) st_d = ST_IDLE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  assign err_set = (in_wait && tmo) || (run && nosync);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pcnt_q  <= '0;
      cs_n_q  <= 1'b1;
      rc_q    <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      words_q <= '0;
    end else begin
      st_q    <= st_d;
      pcnt_q  <= (st_q == ST_PULSE) ? pcnt_q + 1'b1 : '0;
      rc_q    <= !((st_d == ST_ARM) || (st_d == ST_PULSE));
      cs_n_q  <= !((st_d == ST_PULSE) || (st_d == ST_READ));
      valid_q <= (st_q == ST_DONE);
      err_q   <= err_set;
      if (st_q == ST_DONE) words_q <= deser_words;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign rc_o    = rc_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign words_o = words_q;
endmodule

// File: rtl/adc_chain_reader_chk.sv
module adc_chain_reader_chk #(
  parameter int WORDS_W   = 32,
  parameter int PULSE_CYC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_n_o,
  input logic               rc_o,
  input logic               dclk_o,
  input logic [WORDS_W-1:0] words_o,
  input logic               valid_o,
  input logic               err_o
);
  localparam int CW = $clog2(PULSE_CYC + 2) + 1;
  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || rc_o) lo_cnt <= '0;
    else lo_cnt <= lo_cnt + 1'b1;
  end

  // R2
  conv_order_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n_o) && !rc_o) |-> $past(!rc_o));
  // R2
  rc_width_max_chk: assert property (@(posedge clk) disable iff (rst)
    !rc_o |-> (lo_cnt <= CW'(PULSE_CYC)));
  // R2
  rc_width_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rc_o) |-> (lo_cnt == CW'(PULSE_CYC + 1)));
  // R4
  dclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_o || !rc_o) |-> !dclk_o);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R7
  words_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(words_o));
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  // R8
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err_o && valid_o));
endmodule

bind adc_chain_reader adc_chain_reader_chk #(
  .WORDS_W(DATA_W*DEPTH), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .rc_o(rc_o), .dclk_o(dclk_o),
  .words_o(words_o), .valid_o(valid_o), .err_o(err_o)
);

// File: tb/adc_dev_model.sv
// Behavioural model of the converter chain as seen from the host pins.
module adc_dev_model #(
  parameter int DEPTH    = 2,
  parameter int CONV_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rc,
  input  logic              dclk,
  input  logic [16*DEPTH-1:0] words,
  input  logic              null_bit,
  input  logic              stuck_busy,
  input  logic              no_sync,
  output logic              busy_n,
  output logic              sdata,
  output logic              sync
);
  logic cs_d, dclk_d;
  int   conv_left, rises;

  always @(posedge clk) begin
    if (rst) begin
      cs_d <= 1'b1; dclk_d <= 1'b0; conv_left <= 0; rises <= 0;
      busy_n <= 1'b1; sdata <= 1'b0; sync <= 1'b0;
    end else begin
      cs_d   <= cs_n;
      dclk_d <= dclk;
      if (cs_d && !cs_n && !rc) begin
        conv_left <= CONV_CYC;
        busy_n    <= 1'b0;
      end else if (conv_left > 1) begin
        conv_left <= conv_left - 1;
      end else if (conv_left == 1) begin
        conv_left <= 0;
        busy_n    <= stuck_busy ? 1'b0 : 1'b1;
      end
      if (cs_n || !rc) begin
        rises <= 0; sync <= 1'b0; sdata <= 1'b0;
      end else if (!dclk_d && dclk) begin
        rises <= rises + 1;
        sync  <= (rises == 0) ? !no_sync : 1'b0;
        if (rises + 1 >= 2 && rises + 1 <= 17) sdata <= words[17 - (rises + 1)];
        else if (rises + 1 == 18)               sdata <= null_bit;
        else if (DEPTH > 1 && rises + 1 >= 19 && rises + 1 <= 34)
          sdata <= words[50 - (rises + 1)];
        else sdata <= 1'b0;
      end
    end
  end
endmodule

// File: tb/test_adc_chain_reader.sv
`timescale 1ns/1ps
module test_adc_chain_reader;
  localparam int HALF_DIV  = 2;
  localparam int PULSE_CYC = 4;
  localparam int BUSY_TO   = 64;
  localparam int SYNC_WAIT = 4;
  localparam int NVEC      = 6;
  // {null bit value, words (first device low)}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h1234_ABCD}, {1'b1, 32'hFFFF_FFFF}, {1'b0, 32'h0000_0000},
    {1'b1, 32'h8001_7FFE}, {1'b0, 32'hA5A5_5A5A}, {1'b1, 32'h0000_FFFF}
  };

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic start_d = 0, start_s = 0;
  logic [31:0] m_words = '0; logic [15:0] s_words = '0;
  logic m_null = 0, m_stuck = 0, m_nosync = 0;
  logic busy_d, sd_d, sy_d, cs_n_d, rc_d, dclk_d, valid_d, err_d;
  logic busy_s, sd_s, sy_s, cs_n_s, rc_s, dclk_s, valid_s, err_s;
  logic [31:0] words_d; logic [15:0] words_s;

  adc_chain_reader #(.DEPTH(2), .HALF_DIV(HALF_DIV), .PULSE_CYC(PULSE_CYC),
    .BUSY_TO(BUSY_TO), .SYNC_WAIT(SYNC_WAIT)) i_adc_chain_reader (
    .clk(clk), .rst(rst), .start_i(start_d), .busy_n_i(busy_d), .sdata_i(sd_d),
    .sync_i(sy_d), .cs_n_o(cs_n_d), .rc_o(rc_d), .dclk_o(dclk_d),
    .words_o(words_d), .valid_o(valid_d), .err_o(err_d));
  adc_dev_model #(.DEPTH(2)) u_dev_d (
    .clk(clk), .rst(rst), .cs_n(cs_n_d), .rc(rc_d), .dclk(dclk_d), .words(m_words),
    .null_bit(m_null), .stuck_busy(m_stuck), .no_sync(m_nosync),
    .busy_n(busy_d), .sdata(sd_d), .sync(sy_d));

  adc_chain_reader #(.DEPTH(1), .HALF_DIV(HALF_DIV), .PULSE_CYC(PULSE_CYC),
    .BUSY_TO(BUSY_TO), .SYNC_WAIT(SYNC_WAIT)) i_adc_chain_reader_s (
    .clk(clk), .rst(rst), .start_i(start_s), .busy_n_i(busy_s), .sdata_i(sd_s),
    .sync_i(sy_s), .cs_n_o(cs_n_s), .rc_o(rc_s), .dclk_o(dclk_s),
    .words_o(words_s), .valid_o(valid_s), .err_o(err_s));
  adc_dev_model #(.DEPTH(1)) u_dev_s (
    .clk(clk), .rst(rst), .cs_n(cs_n_s), .rc(rc_s), .dclk(dclk_s), .words(s_words),
    .null_bit(1'b0), .stuck_busy(1'b0), .no_sync(1'b0),
    .busy_n(busy_s), .sdata(sd_s), .sync(sy_s));

  // Port monitors for the chained instance
  logic mon_clr = 0, dprev = 0, csprev = 1;
  int rc_only, both_lo, falls, dhi, csf, vcnt, viol;
  always @(posedge clk) begin
    dprev <= dclk_d; csprev <= cs_n_d;
    if (mon_clr) begin
      rc_only <= 0; both_lo <= 0; falls <= 0; dhi <= 0; csf <= 0; vcnt <= 0; viol <= 0;
    end else begin
      if (!rc_d && cs_n_d) rc_only <= rc_only + 1;
      if (!rc_d && !cs_n_d) both_lo <= both_lo + 1;
      if (dprev && !dclk_d) falls <= falls + 1;
      if (dclk_d) dhi <= dhi + 1;
      if (csprev && !cs_n_d) csf <= csf + 1;
      if (valid_d) vcnt <= vcnt + 1;
      if (dclk_d && (cs_n_d || !rc_d)) viol <= viol + 1;
    end
  end

  int total = 0, fails = 0; bit finished = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_d(input logic [31:0] w, input logic nb, input bit again,
                       output logic [31:0] got, output bit sv, output bit se);
    bit fired = 0;
    m_words = w; m_null = nb;
    mon_clr = 1; @(negedge clk); mon_clr = 0;
    start_d = 1; @(negedge clk); start_d = 0;
    sv = 0; se = 0; got = '0;
    for (int i = 0; i < 3000 && !sv && !se; i++) begin
      @(negedge clk);
      start_d = 0;
      if (again && !fired && dclk_d) begin start_d = 1; fired = 1; end
      if (valid_d) begin sv = 1; got = words_d; end
      if (err_d) se = 1;
    end
    start_d = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_s(input logic [15:0] w, output logic [15:0] got, output bit sv);
    s_words = w;
    @(negedge clk); start_s = 1; @(negedge clk); start_s = 0;
    sv = 0; got = '0;
    for (int i = 0; i < 3000 && !sv; i++) begin
      @(negedge clk);
      if (valid_s) begin sv = 1; got = words_s; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got; logic [15:0] gs; bit sv, se;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n_d && rc_d && !dclk_d && !valid_d && !err_d, "R1 reset chained",
        {cs_n_d, rc_d, dclk_d, valid_d, err_d}, 5'b11000);
    chk(cs_n_s && rc_s && !dclk_s && !valid_s && !err_s, "R1 reset single",
        {cs_n_s, rc_s, dclk_s, valid_s, err_s}, 5'b11000);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      run_d(VEC[v][31:0], VEC[v][32], 0, got, sv, se);
      chk(sv && !se, "R7 valid seen", {sv, se}, 2'b10);
      chk(got == VEC[v][31:0], "R5/R6 words", got, VEC[v][31:0]);
      chk(rc_only == 1 && both_lo == PULSE_CYC, "R2 pulse shape",
          {rc_only[15:0], both_lo[15:0]}, {16'd1, 16'(PULSE_CYC)});
      chk(falls == 34, "R6 falling edge count", falls, 34);
      chk(dhi == 34 * HALF_DIV, "R3 clock high time", dhi, 34 * HALF_DIV);
      chk(vcnt == 1, "R7 one strobe", vcnt, 1);
      chk(viol == 0, "R4 clock gated", viol, 0);
    end

    // R6: null bit value must not matter
    run_d(32'h0F0F_F0F0, 1'b0, 0, got, sv, se);
    chk(got == 32'h0F0F_F0F0, "R6 null low", got, 32'h0F0F_F0F0);
    run_d(32'h0F0F_F0F0, 1'b1, 0, got, sv, se);
    chk(got == 32'h0F0F_F0F0, "R6 null high", got, 32'h0F0F_F0F0);

    // R7: words held after the strobe
    repeat (20) @(negedge clk);
    chk(words_d == 32'h0F0F_F0F0 && vcnt == 1, "R7 words held", words_d, 32'h0F0F_F0F0);

    // R10: start during a read is ignored
    run_d(32'hC3C3_3C3C, 1'b0, 1, got, sv, se);
    repeat (40) @(negedge clk);
    chk(got == 32'hC3C3_3C3C, "R10 words", got, 32'hC3C3_3C3C);
    chk(csf == 2 && vcnt == 1 && cs_n_d, "R10 no restart", {csf[7:0], vcnt[7:0]}, 16'h0201);

    // R5: single device
    for (int v = 0; v < 3; v++) begin
      run_s(VEC[v][15:0] ^ 16'h5A00, gs, sv);
      chk(sv && gs == (VEC[v][15:0] ^ 16'h5A00), "R5 single word", gs, VEC[v][15:0] ^ 16'h5A00);
    end

    // R8: busy never releases
    m_stuck = 1;
    run_d(32'h1111_2222, 1'b0, 0, got, sv, se);
    chk(se && !sv, "R8 timeout error", {se, sv}, 2'b10);
    chk(cs_n_d && rc_d && !dclk_d, "R8 idle after timeout", {cs_n_d, rc_d, dclk_d}, 3'b110);
    m_stuck = 0;

    // R9: no sync pulse
    m_nosync = 1;
    run_d(32'h3333_4444, 1'b0, 0, got, sv, se);
    chk(se && !sv, "R9 missing sync error", {se, sv}, 2'b10);
    chk(falls == SYNC_WAIT && cs_n_d, "R9 read ended", falls, SYNC_WAIT);
    m_nosync = 0;

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule